// File: doc/BRIEF.md
# Masked Sticky Error Status Register

This block collects error indications from an audio converter core and presents them to software as one 8-bit read-only status byte on a simple register bus. Two inputs are single-cycle overflow strobes, one for each converter pair. The third is a level that stays high while the clock ratio is invalid. A second register, which software can read and write, selects which sources may appear in the status byte. A source whose mask bit is 0 reads as 0.

The overflow bits are latched. They record any event since the previous status read, and a status read returns the byte and then clears them. The clock-error bit is not latched: it follows its input level. The mask acts only on the read path, so latching goes on while a source is masked.

Software reads one register per cycle by raising `bus_rd` with an address. The byte appears on `bus_rdata` at the following clock edge and stays there until the next read. A write with `bus_wr` takes effect at the clock edge. The bus has no stream traffic and no back-pressure: every access completes in a single cycle and is never stalled.

Top module: `errstat_regs`

## Requirements
- R1: The status byte has the first overflow bit at position 0, the second overflow bit at position 1 and the clock-error bit at position 3. Bits 2 and 4 to 7 always read as 0.
- R2: A one-cycle pulse on `ovf_evt[i]` sets overflow bit i. The bit then holds at 1 over any number of idle cycles until a status read clears it.
- R3: A read at address 0x0 (status) loads `bus_rdata` at the next clock edge with the masked status as it was before the clear. At the same edge it clears both overflow bits. `bus_rdata` keeps its value until the next read.
- R4: Status bit 3 equals `clk_err_lvl` at the read cycle, ANDed with mask bit 3. It is not latched: a later read after the level has dropped returns 0.
- R5: A status bit whose mask bit is 0 reads as 0.
- R6: Overflow bits keep latching while masked. Unmasking without an intervening status read then shows the earlier event.
- R7: An overflow pulse in the same cycle as a status read is not lost. That read returns the pre-clear value, and the next status read shows the bit set.
- R8: A write at address 0x1 (mask) stores only bits 0, 1 and 3. The other mask bits read back as 0. A write at any other address leaves the mask unchanged. A read at 0x1 returns the mask.
- R9: While `rst_n` is low at a clock edge, the overflow bits, the mask and `bus_rdata` all go to 0.
- R10: A read at any other address returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_evt | input | 2 | Overflow strobes, one bit per converter pair |
| clk_err_lvl | input | 1 | High while the clock ratio is invalid |
| bus_addr | input | 4 | Register address: 0x0 status, 0x1 mask |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered, held between reads |

## Verification
The hardest case to reach is an overflow pulse that lands in exactly the cycle of a clearing status read. The expected result then depends on both the pre-clear read value and the bit that survives for the next read. The stimulus drives the strobe and the read in the same cycle and follows with a second read. A second hard case is a source that latches while masked and is revealed later. The bench reaches it by pulsing a source while the mask is zero, writing the mask, and only then reading the status. A mid-run reset after both the mask and a sticky bit are set shows that every stored bit returns to zero.

// File: rtl/errstat_pkg.sv
package errstat_pkg;
  localparam int DATA_W     = 8;
  localparam int OVF_N      = 2;
  localparam int CLKERR_POS = 3;
  localparam int ADDR_W     = 4;

  // Bit map of the implemented status/mask positions.
  function automatic logic [31:0] impl_bits(input int n_ovf, input int clk_pos);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < n_ovf; i++) v[i] = 1'b1;
    v[clk_pos] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/errstat_sticky.sv
module errstat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= set_i | (q_o & ~clr_i);
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o) else $error("sticky bit not set");
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o) else $error("sticky bit lost");
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o) else $error("sticky bit not cleared");
  p_coincident_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i) |=> q_o) else $error("coincident event dropped");
endmodule

// File: rtl/errstat_mask.sv
module errstat_mask #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] IMPL   = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i & IMPL;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_o)) else $error("mask changed without write");
  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (mask_o == '0)) else $error("mask not reset");
endmodule

// File: rtl/errstat_readmux.sv
module errstat_readmux #(
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr_i == STATUS_ADDR)    sel = raw_i & mask_i;
    else if (addr_i == MASK_ADDR) sel = mask_i;
  end

  assign clr_o = rd_i && (addr_i == STATUS_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= sel;
  end

  p_masked_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == STATUS_ADDR) |=> ((rdata_o & ~$past(mask_i)) == '0))
    else $error("masked status bit visible");
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i != STATUS_ADDR && addr_i != MASK_ADDR) |=> (rdata_o == '0))
    else $error("unmapped read nonzero");
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o)) else $error("read data changed without read");
endmodule

// File: rtl/errstat_regs.sv
module errstat_regs
  import errstat_pkg::*;
#(
  parameter int                DATA_W_P    = DATA_W,
  parameter int                OVF_N_P     = OVF_N,
  parameter int                CLK_POS_P   = CLKERR_POS,
  parameter int                ADDR_W_P    = ADDR_W,
  parameter logic [ADDR_W_P-1:0] STATUS_ADDR = 4'h0,
  parameter logic [ADDR_W_P-1:0] MASK_ADDR   = 4'h1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OVF_N_P-1:0]  ovf_evt,
  input  logic                clk_err_lvl,
  input  logic [ADDR_W_P-1:0] bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W_P-1:0] bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W_P-1:0] bus_rdata
);
  localparam logic [31:0]         IMPL_W = impl_bits(OVF_N_P, CLK_POS_P);
  localparam logic [DATA_W_P-1:0] IMPL   = IMPL_W[DATA_W_P-1:0];

  logic [OVF_N_P-1:0]  sticky;
  logic [DATA_W_P-1:0] raw;
  logic [DATA_W_P-1:0] mask;
  logic                stat_clr;
  logic                mask_wr;

  for (genvar g = 0; g < OVF_N_P; g++) begin : g_ovf
    errstat_sticky u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ovf_evt[g]),
      .clr_i (stat_clr),
      .q_o   (sticky[g])
    );
  end

  always_comb begin
    raw                  = '0;
    raw[OVF_N_P-1:0]     = sticky;
    raw[CLK_POS_P]       = clk_err_lvl;
  end

  assign mask_wr = bus_wr && (bus_addr == MASK_ADDR);

  errstat_mask #(.DATA_W(DATA_W_P), .IMPL(IMPL)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr),
    .wdata_i (bus_wdata),
    .mask_o  (mask)
  );

  errstat_readmux #(
    .DATA_W(DATA_W_P), .ADDR_W(ADDR_W_P),
    .STATUS_ADDR(STATUS_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (bus_rd),
    .addr_i  (bus_addr),
    .raw_i   (raw),
    .mask_i  (mask),
    .clr_o   (stat_clr),
    .rdata_o (bus_rdata)
  );

  p_level_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STATUS_ADDR && mask[CLK_POS_P] && clk_err_lvl)
      |=> bus_rdata[CLK_POS_P]) else $error("clock error not shown");
  p_level_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STATUS_ADDR && !clk_err_lvl)
      |=> !bus_rdata[CLK_POS_P]) else $error("clock error latched");
  p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STATUS_ADDR) |=> ((bus_rdata & ~IMPL) == '0))
    else $error("reserved status bit set");
endmodule

// File: tb/test_errstat_regs.sv
module test_errstat_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ovf_evt = '0;
  logic       clk_err_lvl = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] m_stk = '0;
  logic [7:0] m_mask = '0;
  logic       rd_seen = 1'b0;

  always #10 clk = ~clk;

  errstat_regs i_errstat_regs (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .clk_err_lvl(clk_err_lvl),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Driver: one bus cycle; pushes the expected read byte, updates model.
  task automatic cyc(input logic [1:0] ev, input logic ce, input logic rd,
                     input logic wr, input logic [3:0] a, input logic [7:0] wd,
                     input string tag);
    logic [7:0] e;
    ovf_evt = ev; clk_err_lvl = ce; bus_rd = rd; bus_wr = wr;
    bus_addr = a; bus_wdata = wd;
    if (rd) begin
      e = 8'h00;
      if (a == 4'h0) e = {4'b0, ce & m_mask[3], 1'b0, m_stk & m_mask[1:0]};
      else if (a == 4'h1) e = m_mask;
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    if (rd && a == 4'h0) m_stk = 2'b00;
    m_stk = m_stk | ev;
    if (wr && a == 4'h1) m_mask = wd & 8'h0B;
    @(negedge clk);
    ovf_evt = '0; bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n, input logic ce);
    for (int i = 0; i < n; i++) cyc(2'b00, ce, 1'b0, 1'b0, 4'h0, 8'h00, "idle");
  endtask

  // Monitor
  always @(posedge clk) rd_seen <= bus_rd && rst_n;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor: unexpected read data %02h expected none", bus_rdata);
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_rdata, 8'h00, "R9 rdata after reset");
    rst_n = 1'b1;
    @(negedge clk);
    cyc(2'b00, 0, 1, 0, 4'h1, 8'h00, "R9 mask reset value");
    // R5/R6: latch while masked, then unmask
    cyc(2'b01, 0, 0, 0, 4'h0, 8'h00, "");
    cyc(2'b00, 0, 0, 1, 4'h1, 8'h0B, "");
    cyc(2'b00, 0, 1, 0, 4'h0, 8'h00, "R6 unmasked earlier event");
    cyc(2'b00, 0, 1, 0, 4'h0, 8'h00, "R3 cleared after read");
    // R8
    cyc(2'b00, 0, 0, 1, 4'h1, 8'hFF, "");
    cyc(2'b00, 0, 1, 0, 4'h1, 8'h00, "R8 reserved mask bits");
    cyc(2'b00, 0, 0, 1, 4'h0, 8'h00, "");
    cyc(2'b00, 0, 1, 0, 4'h1, 8'h00, "R8 write elsewhere ignored");
    // R2 sticky hold
    cyc(2'b10, 0, 0, 0, 4'h0, 8'h00, "");
    idle(7, 0);
    cyc(2'b00, 0, 1, 0, 4'h0, 8'h00, "R2 sticky overflow bit 1");
    // R4 / R1 level bit
    cyc(2'b00, 1, 1, 0, 4'h0, 8'h00, "R4 R1 clock error level");
    idle(2, 0);
    cyc(2'b00, 0, 1, 0, 4'h0, 8'h00, "R4 level not latched");
    // R7 coincident
    cyc(2'b01, 0, 1, 0, 4'h0, 8'h00, "R7 pre-clear value");
    cyc(2'b00, 0, 1, 0, 4'h0, 8'h00, "R7 coincident event kept");
    // R3 pre-clear both bits and hold
    cyc(2'b11, 1, 0, 0, 4'h0, 8'h00, "");
    cyc(2'b00, 1, 1, 0, 4'h0, 8'h00, "R3 pre-clear data");
    idle(3, 0);
    chk(bus_rdata, 8'h0B, "R3 read data held");
    // R5 partial mask
    cyc(2'b00, 0, 0, 1, 4'h1, 8'h08, "");
    cyc(2'b01, 1, 0, 0, 4'h0, 8'h00, "");
    cyc(2'b00, 1, 1, 0, 4'h0, 8'h00, "R5 masked overflow hidden");
    cyc(2'b00, 0, 0, 1, 4'h1, 8'h0B, "");
    cyc(2'b00, 0, 1, 0, 4'h0, 8'h00, "R5 R3 masked bit cleared too");
    // R10 unmapped
    cyc(2'b01, 1, 0, 0, 4'h0, 8'h00, "");
    cyc(2'b00, 1, 1, 0, 4'h5, 8'h00, "R10 unmapped read");
    cyc(2'b00, 0, 1, 0, 4'h0, 8'h00, "R10 nothing cleared");
    // R9 mid-run reset
    cyc(2'b10, 0, 0, 0, 4'h0, 8'h00, "");
    rst_n = 1'b0; m_stk = '0; m_mask = '0;
    @(negedge clk); @(negedge clk);
    chk(bus_rdata, 8'h00, "R9 rdata cleared by reset");
    rst_n = 1'b1;
    cyc(2'b00, 0, 1, 0, 4'h1, 8'h00, "R9 mask cleared by reset");
    cyc(2'b00, 0, 0, 1, 4'h1, 8'h0B, "");
    cyc(2'b00, 0, 1, 0, 4'h0, 8'h00, "R9 sticky cleared by reset");
    idle(3, 0);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d reads missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule